// File: doc/BRIEF.md
# Accumulator Execute Unit

This block is the execute stage of a small 8-bit accumulator machine that uses 12-bit instruction words. It accepts one instruction per clock, qualified by a valid strobe, and completes it in that same cycle. Four operations are decoded: add a file register to the working register, AND a file register with the working register, AND an 8-bit literal into the working register, and clear one bit of a file register. The unit holds the working register, a 32-entry by 8-bit register file and three status flags (carry, nibble carry and zero).

A destination bit in the two register-operand forms decides whether the result lands in the working register or goes back to the file entry it came from. Each operation updates its own fixed subset of the flags. The flags live outside the addressable file, so no file write can change them. A test port loads and reads any file entry or loads the working register, because the four operations on their own cannot move a nonzero value into a machine that starts cleared.

Top module: `acc_exec_unit`

## Requirements
- R1: Add with destination bit (instr[5]) at 0, encoded as instr[11:6]=000111 with register address in instr[4:0], leaves the 8-bit sum of W and the register in W after the clock edge and leaves the register unchanged.
- R2: Add with destination bit at 1 writes the 8-bit sum into the addressed register and leaves W unchanged.
- R3: An add sets C to the carry out of bit 7, DC to the carry out of bit 3, and Z when the 8-bit result is zero.
- R4: Register AND, encoded as instr[11:6]=000101, computes W AND the register, writes it to W (instr[5]=0) or back to the register (instr[5]=1), updates only Z, and keeps C and DC.
- R5: Literal AND, encoded as instr[11:8]=1110 with the literal in instr[7:0], writes W AND the literal into W and updates only Z.
- R6: Bit clear, encoded as instr[11:8]=0100 with the bit number in instr[7:5] and the register in instr[4:0], clears that bit of the register, leaves its other bits, W and all flags unchanged.
- R7: A valid word that matches none of the four encodings changes neither W, the flags nor the file, and drives illegal_op high for exactly the one cycle after its edge.
- R8: With instr_valid low, the instr input is ignored: W, flags, file and illegal_op do not change.
- R9: A synchronous active-high reset clears W, all three flags, illegal_op and every file entry to zero.
- R10: Instructions issued on consecutive cycles each see the results of the one before.
- R11: A test write (tst_we high) loads W (tst_to_w=1) or the file entry at tst_addr (tst_to_w=0), takes priority over an instruction in the same cycle, and that instruction is then dropped with no effect and no illegal pulse; tst_rdata always shows the entry at tst_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 12 | Instruction word |
| tst_we | input | 1 | Test write enable |
| tst_to_w | input | 1 | Test write targets W (1) or the file (0) |
| tst_addr | input | 5 | Test write and read address |
| tst_wdata | input | 8 | Test write data |
| tst_rdata | output | 8 | File entry at tst_addr |
| w_out | output | 8 | Working register |
| flag_c | output | 1 | Carry flag |
| flag_dc | output | 1 | Nibble carry flag |
| flag_z | output | 1 | Zero flag |
| illegal_op | output | 1 | One-cycle pulse for an unrecognised valid word |

## Verification
A wrong working register value is on w_out directly after the edge that wrote it, and a wrong file entry is on tst_rdata as soon as its address is selected, so every result is observable one cycle after issue. A flag that is wrongly updated or wrongly held persists until the next operation that owns that flag, which is why every one of the 4096 instruction words is executed with freshly loaded operands and its flags compared at once. A decode fault shows either as a missing or extra illegal_op pulse in the cycle after the word, or as a W or file change where none was due.

// File: rtl/acc_exec_pkg.sv
`timescale 1ns/1ps
package acc_exec_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 5;
    localparam int INSTR_W = 12;
    localparam int BIT_W   = 3;
    localparam int NIB_W   = DATA_W / 2;
    localparam int OPC6_W  = INSTR_W - ADDR_W - 1;
    localparam int OPC4_W  = INSTR_W - DATA_W;

    localparam logic [OPC6_W-1:0] OPC_ADD_REG = 6'b000111;
    localparam logic [OPC6_W-1:0] OPC_AND_REG = 6'b000101;
    localparam logic [OPC4_W-1:0] OPC_AND_LIT = 4'b1110;
    localparam logic [OPC4_W-1:0] OPC_BIT_CLR = 4'b0100;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_ADD_REG,
        OP_AND_REG,
        OP_AND_LIT,
        OP_BIT_CLR,
        OP_BAD
    } op_e;

    typedef struct packed {
        logic c;
        logic dc;
        logic z;
    } flags_t;

    typedef struct packed {
        op_e                op;
        logic               to_file;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  lit;
        logic [BIT_W-1:0]   bsel;
    } dec_t;

    typedef struct packed {
        logic [DATA_W-1:0]  value;
        logic               wr_w;
        logic               wr_file;
        flags_t             fl;
        flags_t             fl_we;
    } res_t;

    function automatic op_e classify(input logic [INSTR_W-1:0] iw);
        if (iw[INSTR_W-1 -: OPC6_W] == OPC_ADD_REG) return OP_ADD_REG;
        if (iw[INSTR_W-1 -: OPC6_W] == OPC_AND_REG) return OP_AND_REG;
        if (iw[INSTR_W-1 -: OPC4_W] == OPC_AND_LIT) return OP_AND_LIT;
        if (iw[INSTR_W-1 -: OPC4_W] == OPC_BIT_CLR) return OP_BIT_CLR;
        return OP_BAD;
    endfunction

endpackage

// File: rtl/acc_exec_decode.sv
`timescale 1ns/1ps
module acc_exec_decode
    import acc_exec_pkg::*;
(
    input  logic               valid,
    input  logic [INSTR_W-1:0] iw,
    output dec_t               dec
);

    always_comb begin
        dec.op      = valid ? classify(iw) : OP_IDLE;
        dec.to_file = iw[ADDR_W];
        dec.addr    = iw[ADDR_W-1:0];
        dec.lit     = iw[DATA_W-1:0];
        dec.bsel    = iw[ADDR_W +: BIT_W];
    end

endmodule

// File: rtl/acc_exec_alu.sv
`timescale 1ns/1ps
module acc_exec_alu
    import acc_exec_pkg::*;
(
    input  dec_t              dec,
    input  logic [DATA_W-1:0] w,
    input  logic [DATA_W-1:0] fval,
    output res_t              res
);

    logic [DATA_W:0] sum;
    logic [NIB_W:0]  nib;
    logic [DATA_W-1:0] clr_mask;

    always_comb begin
        sum      = {1'b0, w} + {1'b0, fval};
        nib      = {1'b0, w[NIB_W-1:0]} + {1'b0, fval[NIB_W-1:0]};
        clr_mask = ~(DATA_W'(1) << dec.bsel);
        res      = '0;
        unique case (dec.op)
            OP_ADD_REG: begin
                res.value    = sum[DATA_W-1:0];
                res.wr_w     = !dec.to_file;
                res.wr_file  = dec.to_file;
                res.fl.c     = sum[DATA_W];
                res.fl.dc    = nib[NIB_W];
                res.fl_we    = '1;
            end
            OP_AND_REG: begin
                res.value    = w & fval;
                res.wr_w     = !dec.to_file;
                res.wr_file  = dec.to_file;
                res.fl_we.z  = 1'b1;
            end
            OP_AND_LIT: begin
                res.value    = w & dec.lit;
                res.wr_w     = 1'b1;
                res.fl_we.z  = 1'b1;
            end
            OP_BIT_CLR: begin
                res.value    = fval & clr_mask;
                res.wr_file  = 1'b1;
            end
            default: begin
                res.value    = '0;
            end
        endcase
        res.fl.z = (res.value == '0);
    end

endmodule

// File: rtl/acc_exec_regfile.sv
`timescale 1ns/1ps
module acc_exec_regfile #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] ra_addr,
    output logic [DATA_W-1:0] ra_data,
    input  logic [ADDR_W-1:0] rb_addr,
    output logic [DATA_W-1:0] rb_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];

endmodule

// File: rtl/acc_exec_unit.sv
`timescale 1ns/1ps
module acc_exec_unit
    import acc_exec_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic               tst_we,
    input  logic               tst_to_w,
    input  logic [ADDR_W-1:0]  tst_addr,
    input  logic [DATA_W-1:0]  tst_wdata,
    output logic [DATA_W-1:0]  tst_rdata,
    output logic [DATA_W-1:0]  w_out,
    output logic               flag_c,
    output logic               flag_dc,
    output logic               flag_z,
    output logic               illegal_op
);

    dec_t              dec;
    res_t              res;
    flags_t            fl_q;
    logic [DATA_W-1:0] w_q;
    logic [DATA_W-1:0] f_rdata;
    logic              illegal_q;
    logic              run;
    logic              file_we;
    logic [ADDR_W-1:0] file_waddr;
    logic [DATA_W-1:0] file_wdata;

    acc_exec_decode u_dec (
        .valid (instr_valid),
        .iw    (instr),
        .dec   (dec)
    );

    acc_exec_regfile #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (file_we),
        .waddr   (file_waddr),
        .wdata   (file_wdata),
        .ra_addr (dec.addr),
        .ra_data (f_rdata),
        .rb_addr (tst_addr),
        .rb_data (tst_rdata)
    );

    acc_exec_alu u_alu (
        .dec  (dec),
        .w    (w_q),
        .fval (f_rdata),
        .res  (res)
    );

    // A test write owns the cycle; any instruction alongside it is dropped.
    assign run        = (dec.op != OP_IDLE) && !tst_we;
    assign file_we    = (tst_we && !tst_to_w) || (run && res.wr_file);
    assign file_waddr = tst_we ? tst_addr  : dec.addr;
    assign file_wdata = tst_we ? tst_wdata : res.value;

    always_ff @(posedge clk) begin
        if (rst) begin
            w_q <= '0;
        end else if (tst_we && tst_to_w) begin
            w_q <= tst_wdata;
        end else if (run && res.wr_w) begin
            w_q <= res.value;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_q <= '0;
        end else if (run) begin
            if (res.fl_we.c)  fl_q.c  <= res.fl.c;
            if (res.fl_we.dc) fl_q.dc <= res.fl.dc;
            if (res.fl_we.z)  fl_q.z  <= res.fl.z;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) illegal_q <= 1'b0;
        else     illegal_q <= run && (dec.op == OP_BAD);
    end

    assign w_out      = w_q;
    assign flag_c     = fl_q.c;
    assign flag_dc    = fl_q.dc;
    assign flag_z     = fl_q.z;
    assign illegal_op = illegal_q;

endmodule

// File: rtl/acc_exec_unit_chk.sv
`timescale 1ns/1ps
module acc_exec_unit_chk
    import acc_exec_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               instr_valid,
    input logic [INSTR_W-1:0] instr,
    input logic               tst_we,
    input logic [DATA_W-1:0]  w_out,
    input logic               flag_c,
    input logic               flag_dc,
    input logic               flag_z,
    input logic               illegal_op,
    input logic [DATA_W-1:0]  fsrc
);

    logic go, is_add, is_andf, is_andk, is_bclr, is_bad;
    logic [DATA_W:0] sum9;
    logic [NIB_W:0]  nib5;

    assign go      = instr_valid && !tst_we;
    assign is_add  = instr[11:6] == 6'b000111;
    assign is_andf = instr[11:6] == 6'b000101;
    assign is_andk = instr[11:8] == 4'b1110;
    assign is_bclr = instr[11:8] == 4'b0100;
    assign is_bad  = !(is_add || is_andf || is_andk || is_bclr);
    assign sum9    = {1'b0, w_out} + {1'b0, fsrc};
    assign nib5    = {1'b0, w_out[NIB_W-1:0]} + {1'b0, fsrc[NIB_W-1:0]};

    assert_add_to_w_R1: assert property (@(posedge clk) disable iff (rst)
        go && is_add && !instr[5] |=> w_out == DATA_W'($past(w_out) + $past(fsrc)));

    assert_add_to_file_keeps_w_R2: assert property (@(posedge clk) disable iff (rst)
        go && is_add && instr[5] |=> $stable(w_out));

    assert_add_flags_R3: assert property (@(posedge clk) disable iff (rst)
        go && is_add |=> flag_c == $past(sum9[DATA_W]) && flag_dc == $past(nib5[NIB_W])
                         && flag_z == ($past(sum9[DATA_W-1:0]) == '0));

    assert_and_keeps_carries_R4: assert property (@(posedge clk) disable iff (rst)
        go && (is_andf || is_andk) |=> $stable(flag_c) && $stable(flag_dc));

    assert_literal_and_R5: assert property (@(posedge clk) disable iff (rst)
        go && is_andk |=> w_out == ($past(w_out) & $past(instr[7:0])) && flag_z == (w_out == '0));

    assert_bit_clear_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        go && is_bclr |=> $stable(w_out) && $stable({flag_c, flag_dc, flag_z}));

    assert_illegal_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        go && is_bad |=> illegal_op && $stable(w_out) && $stable({flag_c, flag_dc, flag_z}));

    assert_no_spurious_illegal_R7: assert property (@(posedge clk) disable iff (rst)
        !(go && is_bad) |=> !illegal_op);

    assert_idle_holds_R8: assert property (@(posedge clk) disable iff (rst)
        !instr_valid && !tst_we |=> $stable(w_out) && $stable({flag_c, flag_dc, flag_z}));

    assert_reset_clears_R9: assert property (@(posedge clk)
        rst |=> w_out == '0 && !flag_c && !flag_dc && !flag_z && !illegal_op);

    assert_test_write_priority_R11: assert property (@(posedge clk) disable iff (rst)
        tst_we |=> !illegal_op && $stable({flag_c, flag_dc, flag_z}));

endmodule

bind acc_exec_unit acc_exec_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr       (instr),
    .tst_we      (tst_we),
    .w_out       (w_out),
    .flag_c      (flag_c),
    .flag_dc     (flag_dc),
    .flag_z      (flag_z),
    .illegal_op  (illegal_op),
    .fsrc        (f_rdata)
);

// File: tb/acc_exec_unit_tb.sv
`timescale 1ns/1ps
module acc_exec_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [11:0] instr = '0;
    logic        tst_we = 1'b0;
    logic        tst_to_w = 1'b0;
    logic [4:0]  tst_addr = '0;
    logic [7:0]  tst_wdata = '0;
    logic [7:0]  tst_rdata;
    logic [7:0]  w_out;
    logic        flag_c, flag_dc, flag_z, illegal_op;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] m_w;
    logic [7:0] m_mem [32];
    logic       m_c, m_dc, m_z;

    always #5 clk = ~clk;

    acc_exec_unit u_dut (
        .clk (clk), .rst (rst), .instr_valid (instr_valid), .instr (instr),
        .tst_we (tst_we), .tst_to_w (tst_to_w), .tst_addr (tst_addr),
        .tst_wdata (tst_wdata), .tst_rdata (tst_rdata), .w_out (w_out),
        .flag_c (flag_c), .flag_dc (flag_dc), .flag_z (flag_z),
        .illegal_op (illegal_op)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        m_w = '0; m_c = 0; m_dc = 0; m_z = 0;
        for (int i = 0; i < 32; i++) m_mem[i] = '0;
    endtask

    // Expected effect of one word, derived from the requirement text.
    task automatic model_step(input logic [11:0] iw, output bit bad,
                              output string reqv, output string reqf);
        logic [8:0] s;
        logic [4:0] n;
        logic [7:0] r;
        logic [4:0] a;
        a = iw[4:0];
        bad = 0;
        if (iw[11:6] == 6'b000111) begin
            s = {1'b0, m_w} + {1'b0, m_mem[a]};
            n = {1'b0, m_w[3:0]} + {1'b0, m_mem[a][3:0]};
            r = s[7:0];
            if (iw[5]) m_mem[a] = r; else m_w = r;
            m_c = s[8]; m_dc = n[4]; m_z = (r == 0);
            reqv = iw[5] ? "R2" : "R1"; reqf = "R3";
        end else if (iw[11:6] == 6'b000101) begin
            r = m_w & m_mem[a];
            if (iw[5]) m_mem[a] = r; else m_w = r;
            m_z = (r == 0);
            reqv = "R4"; reqf = "R4";
        end else if (iw[11:8] == 4'b1110) begin
            m_w = m_w & iw[7:0];
            m_z = (m_w == 0);
            reqv = "R5"; reqf = "R5";
        end else if (iw[11:8] == 4'b0100) begin
            m_mem[a][iw[7:5]] = 1'b0;
            reqv = "R6"; reqf = "R6";
        end else begin
            bad = 1;
            reqv = "R7"; reqf = "R7";
        end
    endtask

    task automatic load_w(input logic [7:0] v);
        @(negedge clk); tst_we = 1; tst_to_w = 1; tst_wdata = v;
        @(negedge clk); tst_we = 0;
        m_w = v;
    endtask

    task automatic load_f(input logic [4:0] a, input logic [7:0] v);
        @(negedge clk); tst_we = 1; tst_to_w = 0; tst_addr = a; tst_wdata = v;
        @(negedge clk); tst_we = 0;
        m_mem[a] = v;
    endtask

    task automatic exec(input logic [11:0] iw, output bit bad,
                        output string reqv, output string reqf);
        @(negedge clk); instr_valid = 1; instr = iw;
        @(negedge clk); instr_valid = 0;
        model_step(iw, bad, reqv, reqf);
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] v);
        tst_addr = a;
        #1 v = tst_rdata;
    endtask

    task automatic check_state(input string reqv, input string reqf,
                               input logic [4:0] a);
        logic [7:0] v;
        chk(reqv, w_out, m_w);
        rd(a, v);
        chk(reqv, v, m_mem[a]);
        chk(reqf, {flag_c, flag_dc, flag_z}, {m_c, m_dc, m_z});
    endtask

    task automatic check_all_zero(input string req);
        logic [7:0] v;
        chk(req, {w_out, flag_c, flag_dc, flag_z, illegal_op}, 0);
        for (int i = 0; i < 32; i++) begin
            rd(5'(i), v);
            chk(req, v, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit bad;
        string rv, rf;
        logic [7:0] v;

        model_clear();
        repeat (3) @(negedge clk);
        rst = 0;
        // R9: state straight out of reset
        check_all_zero("R9");

        // Worked examples for R1, R4, R5, R6
        load_w(8'h17); load_f(5'd9, 8'hC2);
        exec(12'h1C9, bad, rv, rf);
        chk("R1", w_out, 8'hD9); rd(5'd9, v); chk("R1", v, 8'hC2);
        load_w(8'h17); load_f(5'd9, 8'hC2);
        exec(12'h169, bad, rv, rf);
        chk("R4", w_out, 8'h17); rd(5'd9, v); chk("R4", v, 8'h02);
        load_w(8'hA3);
        exec(12'hE5F, bad, rv, rf);
        chk("R5", w_out, 8'h03);
        load_f(5'd9, 8'hC7);
        exec(12'h4E9, bad, rv, rf);
        rd(5'd9, v); chk("R6", v, 8'h47);

        // R7: pulse lasts exactly one cycle
        exec(12'h000, bad, rv, rf);
        chk("R7", illegal_op, 1);
        @(negedge clk);
        chk("R7", illegal_op, 0);

        // Every instruction word, with fresh operands each time
        for (int code = 0; code < 4096; code++) begin
            logic [4:0] a;
            a = 5'(code);
            load_w(8'((code * 37 + 11) & 255));
            load_f(a, 8'((code * 91 + 5) & 255));
            exec(12'(code), bad, rv, rf);
            chk("R7", illegal_op, bad);
            check_state(rv, rf, a);
        end

        // Dense add sweep, both destinations (R1, R2, R3)
        for (int wv = 0; wv < 256; wv += 3) begin
            for (int fv = 0; fv < 256; fv += 13) begin
                logic [4:0] a;
                logic [11:0] iw;
                a  = 5'((wv + fv) & 31);
                iw = {6'b000111, 1'(fv >> 2), a};
                load_w(8'(wv));
                load_f(a, 8'(fv));
                exec(iw, bad, rv, rf);
                check_state(rv, rf, a);
            end
        end

        // R8: strobe low, word ignored
        load_w(8'h3C); load_f(5'd4, 8'h81);
        @(negedge clk); instr_valid = 0; instr = 12'h1E4;
        @(negedge clk); instr = 12'h000;
        @(negedge clk);
        chk("R8", illegal_op, 0);
        check_state("R8", "R8", 5'd4);

        // R10: back-to-back, second word consumes first result
        load_w(8'h01); load_f(5'd5, 8'h01);
        @(negedge clk); instr_valid = 1; instr = 12'h1E5;
        @(negedge clk); instr = 12'h1C5;
        @(negedge clk); instr_valid = 0;
        model_step(12'h1E5, bad, rv, rf);
        model_step(12'h1C5, bad, rv, rf);
        chk("R10", w_out, 8'h03);
        rd(5'd5, v); chk("R10", v, 8'h02);
        check_state("R10", "R10", 5'd5);

        // R11: test write wins, instruction dropped
        load_w(8'h40); load_f(5'd3, 8'h10);
        @(negedge clk); instr_valid = 1; instr = 12'h1C3;
        tst_we = 1; tst_to_w = 0; tst_addr = 5'd3; tst_wdata = 8'h55;
        @(negedge clk); instr_valid = 0; tst_we = 0;
        m_mem[3] = 8'h55;
        check_state("R11", "R11", 5'd3);
        @(negedge clk); instr_valid = 1; instr = 12'h000;
        tst_we = 1; tst_to_w = 1; tst_wdata = 8'h66;
        @(negedge clk); instr_valid = 0; tst_we = 0;
        m_w = 8'h66;
        chk("R11", illegal_op, 0);
        chk("R11", w_out, 8'h66);

        // R9: reset in mid-run
        load_f(5'd31, 8'hFF); load_w(8'hFF);
        exec(12'h1DF, bad, rv, rf);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        model_clear();
        check_all_zero("R9");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule